// File: doc/BRIEF.md
# Chainable Performance Event Counter Bank

This block holds a bank of event counters that are configured and read through a word-wide register port. Each counter has its own event number. It counts the cycles on which the event input with that number is high. Any counter can instead be told to count clock cycles. Any even-numbered counter can be joined to the odd counter above it, which gives one counter of twice the width. The even half holds the low word and the odd half holds the high word.

All counters start and stop together under one enable bit. A self-clearing clear bit zeroes the whole bank. Software can also zero a single counter by writing zero to its value register. When a joined pair is read while it is running, the read is made coherent by a shadow copy: reading the low half captures the high half at that moment.

Register byte offsets:

| Offset | Register |
|---|---|
| 0x00 | control |
| 0x04 | cycle-count select |
| 0x0C + 4·i | value register of counter i |
| 0x40 + 4·i | event select register of counter i |

Top module: `evctr_bank`

## Requirements
- R1: After reset, every counter, the control register, the cycle-count select register and every event select register read as zero, and `reg_rvalid` is low.
- R2: Control bit 30 is the run enable. While it is 1, counting proceeds. While it is 0, every counter holds its value, and writes to the event selects, the masks and the value registers still take effect.
- R3: A counter whose event select holds a number e below `NUM_EVENTS` adds one on each enabled clock edge at which `event_in[e]` is high. Its event select reads back the value last written.
- R4: An event select value of `NUM_EVENTS` or above never increments its counter.
- R5: Setting bit i of the cycle-count select register (offset 0x04) makes counter i add one on every enabled edge, whatever its event inputs do. The register reads back as written.
- R6: A counter that is not joined is `CTR_W` bits wide (32 by default). It wraps from all ones to zero and never changes by more than +1 per cycle except when cleared.
- R7: Writing 0 to the value register at 0x0C + 4·i zeroes counter i on the next edge. Writing any nonzero value leaves the counter unchanged.
- R8: Writing control bit 28 as 1 zeroes every counter on the next edge. Bit 28 always reads back as 0.
- R9: Control bit j (j < `NUM_CTRS`/2, within bits 15:0) joins counter 2j with counter 2j+1. The odd half then increments only when the even half increments while all ones, and its own event and cycle selections are ignored. Unimplemented mask bits read as 0.
- R10: Reading the even half of a joined pair captures the odd half into a shadow register. The next read of the odd half returns that captured value. A later read of the odd half returns the live value.
- R11: `reg_rdata` is valid with `reg_rvalid` high exactly one cycle after a cycle with `reg_rd` high, and `reg_rvalid` is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| event_in | input | NUM_EVENTS | Event inputs, one per event number |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |

## Verification
The hardest situations to reach are a counter wrapping and the carry into the high half of a joined pair. At the default width, either one needs billions of cycles, because the value registers can only be written with zero. The bench therefore builds the bank with an 8-bit `CTR_W`, so a wrap comes after 256 counts. It then counts clock cycles across that boundary. To test the coherent read, it reads the low half of a running pair before the carry and the high half after it. The first high read must return the captured value and the second must return the live value.

// File: rtl/evctr_pkg.sv
// Package: register offsets, control bit positions and the address decoder
// shared by the counter bank modules.
package evctr_pkg;

    localparam int OFS_CTRL     = 0;
    localparam int OFS_CYCSEL   = 4;
    localparam int OFS_VALUE    = 12;
    localparam int OFS_EVSEL    = 64;
    localparam int EN_BIT       = 30;
    localparam int CLR_BIT      = 28;
    localparam int PAIR_FIELD_W = 16;
    localparam int IDX_FIELD_W  = 8;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_CTRL,
        RK_CYCSEL,
        RK_VALUE,
        RK_EVSEL
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e              kind;
        logic [IDX_FIELD_W-1:0] idx;
    } reg_sel_t;

    // Map a byte address to a register kind and a counter index.
    function automatic reg_sel_t decode_addr(input logic [15:0] addr, input int n_ctrs);
        reg_sel_t s;
        int a;
        s.kind = RK_NONE;
        s.idx  = '0;
        a      = int'(addr);
        if (addr[1:0] == 2'b00) begin
            if (a == OFS_CTRL) begin
                s.kind = RK_CTRL;
            end else if (a == OFS_CYCSEL) begin
                s.kind = RK_CYCSEL;
            end else if (a >= OFS_VALUE && a < OFS_VALUE + 4 * n_ctrs) begin
                s.kind = RK_VALUE;
                s.idx  = IDX_FIELD_W'((a - OFS_VALUE) / 4);
            end else if (a >= OFS_EVSEL && a < OFS_EVSEL + 4 * n_ctrs) begin
                s.kind = RK_EVSEL;
                s.idx  = IDX_FIELD_W'((a - OFS_EVSEL) / 4);
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/evctr_counter.sv
// One counter cell of the bank.
// Assumes clr has priority over inc. Wraps naturally at 2**W.
module evctr_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value,
    output logic         at_max
);

    // Count register: reset, clear, or step by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (clr) begin
            value <= '0;
        end else if (inc) begin
            value <= value + 1'b1;
        end
    end

    // Flag used by the chaining logic for carry generation.
    assign at_max = (value == {W{1'b1}});

endmodule

// File: rtl/evctr_evsel.sv
// Per-counter event selection.
// own_hit[i] is high when counter i would step this cycle on its own
// selection: either cycle mode, or its selected event is asserted.
// Event numbers at or above NUM_EVENTS match nothing.
module evctr_evsel #(
    parameter int NUM_CTRS   = 8,
    parameter int NUM_EVENTS = 12,
    parameter int EVSEL_W    = 5
) (
    input  logic [NUM_EVENTS-1:0]             event_in,
    input  logic [NUM_CTRS-1:0]               cyc_sel,
    input  logic [NUM_CTRS-1:0][EVSEL_W-1:0]  evsel,
    output logic [NUM_CTRS-1:0]               own_hit
);

    // Compare each counter's event number against every implemented event.
    always_comb begin
        for (int i = 0; i < NUM_CTRS; i++) begin
            own_hit[i] = cyc_sel[i];
            for (int e = 0; e < NUM_EVENTS; e++) begin
                if (evsel[i] == EVSEL_W'(e) && event_in[e]) begin
                    own_hit[i] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/evctr_regs.sv
// Register file of the counter bank.
// Holds run enable, pair mask, cycle select and event selects. Decodes the
// clear requests and returns read data one cycle after reg_rd. Keeps one
// shadow word per pair for coherent reads of joined counters.
// Assumes NUM_CTRS is even and at least 4, and CTR_W <= 32.
module evctr_regs
    import evctr_pkg::*;
#(
    parameter int NUM_CTRS = 8,
    parameter int CTR_W    = 32,
    parameter int EVSEL_W  = 5,
    parameter int ADDR_W   = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              reg_wr,
    input  logic                              reg_rd,
    input  logic [ADDR_W-1:0]                 reg_addr,
    input  logic [31:0]                       reg_wdata,
    output logic [31:0]                       reg_rdata,
    output logic                              reg_rvalid,
    input  logic [NUM_CTRS-1:0][CTR_W-1:0]    cnt_vals,
    output logic                              cfg_en,
    output logic [NUM_CTRS/2-1:0]             cfg_pair,
    output logic [NUM_CTRS-1:0]               cfg_cyc,
    output logic [NUM_CTRS-1:0][EVSEL_W-1:0]  cfg_evsel,
    output logic [NUM_CTRS-1:0]               clr_vec
);

    localparam int NP    = NUM_CTRS / 2;
    localparam int IDX_W = $clog2(NUM_CTRS);

    reg_sel_t            dec;
    logic [IDX_W-1:0]    sel_idx;
    logic [IDX_W-2:0]    sel_pair;
    logic                clr_all;
    logic [31:0]         rd_mux;
    logic [NP-1:0][CTR_W-1:0] shadow;
    logic [NP-1:0]       shadow_vld;

    assign dec      = decode_addr(16'(reg_addr), NUM_CTRS);
    assign sel_idx  = dec.idx[IDX_W-1:0];
    assign sel_pair = sel_idx[IDX_W-1:1];

    // Configuration registers written through the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_en    <= 1'b0;
            cfg_pair  <= '0;
            cfg_cyc   <= '0;
            cfg_evsel <= '0;
        end else if (reg_wr) begin
            case (dec.kind)
                RK_CTRL: begin
                    cfg_en   <= reg_wdata[EN_BIT];
                    cfg_pair <= reg_wdata[NP-1:0];
                end
                RK_CYCSEL: cfg_cyc <= reg_wdata[NUM_CTRS-1:0];
                RK_EVSEL:  cfg_evsel[sel_idx] <= reg_wdata[EVSEL_W-1:0];
                default: ;
            endcase
        end
    end

    // Clear requests: global clear bit, or a zero write to one value register.
    assign clr_all = reg_wr && (dec.kind == RK_CTRL) && reg_wdata[CLR_BIT];
    always_comb begin
        for (int i = 0; i < NUM_CTRS; i++) begin
            clr_vec[i] = clr_all ||
                (reg_wr && dec.kind == RK_VALUE && int'(sel_idx) == i && reg_wdata == '0);
        end
    end

    // Shadow capture on a low-half read of a joined pair, release on a high-half read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow     <= '0;
            shadow_vld <= '0;
        end else if (reg_rd && dec.kind == RK_VALUE) begin
            for (int j = 0; j < NP; j++) begin
                if (int'(sel_pair) == j) begin
                    if (!sel_idx[0] && cfg_pair[j]) begin
                        shadow[j]     <= cnt_vals[2*j+1];
                        shadow_vld[j] <= 1'b1;
                    end else if (sel_idx[0]) begin
                        shadow_vld[j] <= 1'b0;
                    end
                end
            end
        end
    end

    // Read data selection.
    always_comb begin
        rd_mux = '0;
        case (dec.kind)
            RK_CTRL: begin
                rd_mux[EN_BIT] = cfg_en;
                rd_mux[NP-1:0] = cfg_pair;
            end
            RK_CYCSEL: rd_mux[NUM_CTRS-1:0] = cfg_cyc;
            RK_EVSEL:  rd_mux[EVSEL_W-1:0]  = cfg_evsel[sel_idx];
            RK_VALUE: begin
                if (sel_idx[0] && cfg_pair[sel_pair] && shadow_vld[sel_pair]) begin
                    rd_mux[CTR_W-1:0] = shadow[sel_pair];
                end else begin
                    rd_mux[CTR_W-1:0] = cnt_vals[sel_idx];
                end
            end
            default: ;
        endcase
    end

    // Registered read response, one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            reg_rvalid <= reg_rd;
            if (reg_rd) begin
                reg_rdata <= rd_mux;
            end
        end
    end

endmodule

// File: rtl/evctr_bank.sv
// Top of the chainable event counter bank.
// Instantiates the register file, the event selector and one counter cell
// per counter. Odd counters take the carry of their even neighbour when the
// pair is joined. Assumes NUM_CTRS even, 4..13, and CTR_W <= 32.
module evctr_bank #(
    parameter int NUM_CTRS   = 8,
    parameter int CTR_W      = 32,
    parameter int NUM_EVENTS = 12,
    parameter int EVSEL_W    = 5,
    parameter int ADDR_W     = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_EVENTS-1:0] event_in,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    output logic                  reg_rvalid
);

    localparam int NP = NUM_CTRS / 2;

    logic                              cfg_en;
    logic [NP-1:0]                     cfg_pair;
    logic [NUM_CTRS-1:0]               cfg_cyc;
    logic [NUM_CTRS-1:0][EVSEL_W-1:0]  cfg_evsel;
    logic [NUM_CTRS-1:0]               clr_vec;
    logic [NUM_CTRS-1:0]               own_hit;
    logic [NUM_CTRS-1:0]               inc_vec;
    logic [NUM_CTRS-1:0]               at_max;
    logic [NUM_CTRS-1:0][CTR_W-1:0]    cnt_vals;

    evctr_regs #(
        .NUM_CTRS (NUM_CTRS),
        .CTR_W    (CTR_W),
        .EVSEL_W  (EVSEL_W),
        .ADDR_W   (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .reg_rvalid (reg_rvalid),
        .cnt_vals   (cnt_vals),
        .cfg_en     (cfg_en),
        .cfg_pair   (cfg_pair),
        .cfg_cyc    (cfg_cyc),
        .cfg_evsel  (cfg_evsel),
        .clr_vec    (clr_vec)
    );

    evctr_evsel #(
        .NUM_CTRS   (NUM_CTRS),
        .NUM_EVENTS (NUM_EVENTS),
        .EVSEL_W    (EVSEL_W)
    ) u_evsel (
        .event_in (event_in),
        .cyc_sel  (cfg_cyc),
        .evsel    (cfg_evsel),
        .own_hit  (own_hit)
    );

    for (genvar i = 0; i < NUM_CTRS; i++) begin : g_ctr
        if (i % 2 == 0) begin : g_even
            // Even counters always count on their own selection.
            assign inc_vec[i] = cfg_en && own_hit[i];
        end else begin : g_odd
            // Odd counters take the neighbour's carry while joined.
            assign inc_vec[i] = cfg_pair[i/2]
                ? (inc_vec[i-1] && at_max[i-1] && !clr_vec[i-1])
                : (cfg_en && own_hit[i]);
        end

        evctr_counter #(
            .W (CTR_W)
        ) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr_vec[i]),
            .inc    (inc_vec[i]),
            .value  (cnt_vals[i]),
            .at_max (at_max[i])
        );
    end

endmodule

// File: rtl/evctr_bank_checker.sv
// Assertion checker for evctr_bank, attached with bind below.
// Observes the register port, the configuration outputs of the register
// file, the increment strobes and the counter values.
module evctr_bank_checker #(
    parameter int NUM_CTRS   = 8,
    parameter int CTR_W      = 32,
    parameter int NUM_EVENTS = 12,
    parameter int EVSEL_W    = 5
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              reg_rd,
    input logic                              reg_rvalid,
    input logic                              cfg_en,
    input logic [NUM_CTRS/2-1:0]             cfg_pair,
    input logic [NUM_CTRS-1:0]               cfg_cyc,
    input logic [NUM_CTRS-1:0][EVSEL_W-1:0]  cfg_evsel,
    input logic [NUM_CTRS-1:0]               clr_vec,
    input logic [NUM_CTRS-1:0]               inc_vec,
    input logic [NUM_CTRS-1:0][CTR_W-1:0]    cnt_vals
);

    // R11: a read strobe is answered exactly one cycle later.
    assert_rvalid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid);
    assert_no_stray_rvalid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> !reg_rvalid);

    // R2: with the bank stopped and no clear, nothing moves.
    assert_hold_when_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && clr_vec == '0) |=> $stable(cnt_vals));

    for (genvar i = 0; i < NUM_CTRS; i++) begin : g_chk
        // R6: a counter holds, steps by one, or goes to zero.
        assert_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (cnt_vals[i] == $past(cnt_vals[i]) ||
                      cnt_vals[i] == CTR_W'($past(cnt_vals[i]) + 1'b1) ||
                      cnt_vals[i] == '0));

        // R8 (and R7): a clear request zeroes the counter on the next edge.
        assert_zero_on_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            clr_vec[i] |=> cnt_vals[i] == '0);

        // R4: an unimplemented event number never produces an increment.
        if (i % 2 == 0) begin : g_even
            assert_bad_event_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (int'(cfg_evsel[i]) >= NUM_EVENTS && !cfg_cyc[i]) |-> !inc_vec[i]);
        end else begin : g_odd
            assert_bad_event_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (int'(cfg_evsel[i]) >= NUM_EVENTS && !cfg_cyc[i] && !cfg_pair[i/2])
                    |-> !inc_vec[i]);
        end
    end

    for (genvar j = 0; j < NUM_CTRS / 2; j++) begin : g_pair
        // R9: the low half rolling over carries into the high half.
        assert_pair_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_pair[j] && inc_vec[2*j] && cnt_vals[2*j] == {CTR_W{1'b1}} &&
             !clr_vec[2*j] && !clr_vec[2*j+1])
                |=> cnt_vals[2*j+1] == CTR_W'($past(cnt_vals[2*j+1]) + 1'b1));
    end

endmodule

bind evctr_bank evctr_bank_checker #(
    .NUM_CTRS   (NUM_CTRS),
    .CTR_W      (CTR_W),
    .NUM_EVENTS (NUM_EVENTS),
    .EVSEL_W    (EVSEL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_rd     (reg_rd),
    .reg_rvalid (reg_rvalid),
    .cfg_en     (cfg_en),
    .cfg_pair   (cfg_pair),
    .cfg_cyc    (cfg_cyc),
    .cfg_evsel  (cfg_evsel),
    .clr_vec    (clr_vec),
    .inc_vec    (inc_vec),
    .cnt_vals   (cnt_vals)
);

// File: tb/evctr_bank_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks push expected words, a monitor pops them
// when reg_rvalid arrives. Built with 8-bit counters so wraps are reachable.
module evctr_bank_bench;

    localparam int N    = 8;
    localparam int W    = 8;
    localparam int NEV  = 12;
    localparam int ESW  = 5;
    localparam int AW   = 8;
    localparam logic [31:0] EN  = 32'h4000_0000;
    localparam logic [31:0] CLR = 32'h1000_0000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NEV-1:0] event_in = '0;
    logic           reg_wr = 1'b0;
    logic           reg_rd = 1'b0;
    logic [AW-1:0]  reg_addr = '0;
    logic [31:0]    reg_wdata = '0;
    logic [31:0]    reg_rdata;
    logic           reg_rvalid;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [31:0] exp_q[$];
    bit          chk_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    evctr_bank #(
        .NUM_CTRS   (N),
        .CTR_W      (W),
        .NUM_EVENTS (NEV),
        .EVSEL_W    (ESW),
        .ADDR_W     (AW)
    ) u_evctr_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .event_in   (event_in),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .reg_rvalid (reg_rvalid)
    );

    function automatic logic [AW-1:0] val_a(input int i);
        return AW'(12 + 4 * i);
    endfunction

    function automatic logic [AW-1:0] evs_a(input int i);
        return AW'(64 + 4 * i);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // All driver tasks start and end at a falling edge.
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input bit c, input string tag);
        exp_q.push_back(e); chk_q.push_back(c); tag_q.push_back(tag);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pulse(input logic [NEV-1:0] m);
        event_in = m;
        @(negedge clk);
        event_in = '0;
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    // Monitor: compare every read response against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && reg_rvalid) begin
            if (exp_q.size() == 0) begin
                check("R11 response without read", 32'd1, 32'd0);
            end else begin
                logic [31:0] e;
                bit c;
                string t;
                e = exp_q.pop_front(); c = chk_q.pop_front(); t = tag_q.pop_front();
                if (c) check(t, reg_rdata, e);
            end
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        check("R1 rvalid after reset", 32'(reg_rvalid), 32'd0);
        rd(AW'(0), 32'h0, 1, "R1 control");
        rd(AW'(4), 32'h0, 1, "R1 cycle select");
        rd(val_a(0), 32'h0, 1, "R1 counter0");
        rd(evs_a(3), 32'h0, 1, "R1 evsel3");

        // R3: event counting and readback
        wr(evs_a(2), 32'd5);
        wr(evs_a(3), 32'd7);
        rd(evs_a(2), 32'd5, 1, "R3 evsel2 readback");
        wr(AW'(0), EN);
        pulse(12'h020); pulse(12'h020); pulse(12'h020);
        pulse(12'h0A0); pulse(12'h080); pulse(12'h001);
        wr(AW'(0), 32'h0);
        rd(val_a(2), 32'd4, 1, "R3 counter2 event5");
        rd(val_a(3), 32'd2, 1, "R3 counter3 event7");
        rd(val_a(0), 32'd1, 1, "R3 counter0 event0");
        rd(val_a(1), 32'd1, 1, "R3 counter1 event0 unjoined");

        // R2: stopped bank holds, config writes still land
        pulse(12'h020); pulse(12'hFFF);
        wr(evs_a(2), 32'd9);
        rd(evs_a(2), 32'd9, 1, "R2 evsel write while stopped");
        rd(val_a(2), 32'd4, 1, "R2 counter2 holds while stopped");

        // R7: zero write clears one counter, nonzero ignored
        wr(val_a(2), 32'h55);
        rd(val_a(2), 32'd4, 1, "R7 nonzero write ignored");
        wr(val_a(2), 32'h0);
        rd(val_a(2), 32'd0, 1, "R7 zero write clears");
        rd(val_a(3), 32'd2, 1, "R7 neighbour untouched");

        // R8: global clear, clear bit reads 0; R9 mask width
        wr(AW'(0), CLR);
        rd(val_a(3), 32'd0, 1, "R8 counter3 cleared");
        rd(val_a(0), 32'd0, 1, "R8 counter0 cleared");
        wr(AW'(0), EN | CLR | 32'hFFFF);
        rd(AW'(0), 32'h4000_000F, 1, "R8 R9 control readback");
        wr(AW'(0), 32'h0);

        // R4: out-of-range event number
        wr(evs_a(3), 32'd20);
        wr(evs_a(2), 32'd11);
        wr(AW'(0), EN);
        pulse(12'hFFF); pulse(12'hFFF); pulse(12'hFFF);
        wr(AW'(0), 32'h0);
        rd(val_a(3), 32'd0, 1, "R4 evsel 20 never counts");
        rd(val_a(2), 32'd3, 1, "R4 evsel 11 counts");

        // R5: cycle counting overrides events
        wr(AW'(0), CLR);
        wr(AW'(4), 32'h22);
        wr(AW'(0), EN);
        pulse(12'hFFF); pulse(12'hFFF); idle(7);
        wr(AW'(0), 32'h0);
        rd(val_a(1), 32'd10, 1, "R5 counter1 cycles");
        rd(val_a(5), 32'd10, 1, "R5 counter5 cycles");
        rd(val_a(0), 32'd2, 1, "R5 counter0 events only");
        rd(AW'(4), 32'h22, 1, "R5 cycle select readback");

        // R6: wrap of an unjoined counter, no carry to neighbour
        wr(AW'(0), CLR);
        wr(AW'(4), 32'h01);
        wr(AW'(0), EN);
        idle(256);
        wr(AW'(0), 32'h0);
        rd(val_a(0), 32'd1, 1, "R6 wrap after 257 counts");
        rd(val_a(1), 32'd0, 1, "R6 R9 no carry when unjoined");

        // R9: joined pair, odd own selections ignored
        wr(AW'(0), CLR);
        wr(AW'(4), 32'h03);
        wr(evs_a(1), 32'd0);
        wr(AW'(0), EN | 32'h1);
        pulse(12'h001); pulse(12'h001); pulse(12'h001);
        idle(296);
        wr(AW'(0), 32'h1);
        rd(val_a(0), 32'd44, 1, "R9 pair low half");
        rd(val_a(1), 32'd1, 1, "R9 pair high half");

        // R10: coherent read across a carry
        wr(AW'(0), CLR | 32'h1);
        wr(AW'(0), EN | 32'h1);
        idle(100);
        rd(val_a(0), 32'h0, 0, "R10 low half while running");
        idle(200);
        wr(AW'(0), 32'h1);
        rd(val_a(1), 32'd0, 1, "R10 high half from shadow");
        rd(val_a(1), 32'd1, 1, "R10 high half live");
        rd(val_a(0), 32'd46, 1, "R10 low half final");

        // R11: response timing at the port
        exp_q.push_back(32'h1); chk_q.push_back(1'b1); tag_q.push_back("R11 data");
        reg_rd = 1'b1; reg_addr = AW'(0);
        @(negedge clk);
        reg_rd = 1'b0;
        check("R11 rvalid one cycle after read", 32'(reg_rvalid), 32'd1);
        @(negedge clk);
        check("R11 rvalid drops", 32'(reg_rvalid), 32'd0);

        idle(4);
        check("R11 all reads answered", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule